// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block decides where each access into the 256 KB upper-memory window at 0xC0000..0xFFFFF is served: by on-board DRAM (the shadow copy) or by the external expansion bus. The window is split into four 64 KB areas. Each area has one 8-bit control byte. In that byte, four low bits turn shadowing on for the area's four 16 KB segments, one bit steers reads and one bit steers writes.

The memory controller presents a 20-bit address and a write flag every cycle. One cycle later the block raises exactly one of two selects, internal or external, when the address lies inside the window. Outside the window it claims nothing. A one-cycle change pulse reports any edit to the control bytes, so that translation or line caches downstream can be invalidated. The control bytes are supplied by the register file that owns them.

Top module: `shadow_route_decoder`

## Requirements
- R1: Control byte k, which is areaCtrl[8k+7:8k], governs the 64 KB area starting at 0xC0000 + k*0x10000, for k = 0..3. Byte 0 covers 0xC0000, byte 1 covers 0xD0000, byte 2 covers 0xE0000 and byte 3 covers 0xF0000.
- R2: Bit s (s = 0..3) of a control byte enables shadowing of the 16 KB segment at offset s*0x4000 within that area. Address bits [15:14] carry s.
- R3: A read (isWrite = 0) of an enabled segment selects internal memory when bit 4 of its control byte is 1, and selects external memory otherwise.
- R4: A write (isWrite = 1) of an enabled segment selects internal memory when bit 5 of its control byte is 1, and selects external memory otherwise.
- R5: An access to a segment whose enable bit is 0 selects external memory, whatever bits 4 and 5 hold.
- R6: An address below 0xC0000, where addr[19:18] is not 2'b11, raises neither intSel nor extSel.
- R7: The selects appear on the first rising clock edge after the address is sampled. Inside the window exactly one of intSel and extSel is high. The two are never high together.
- R8: cfgChanged is high for exactly the one cycle that follows a rising edge at which areaCtrl differs from its value at the previous edge. The stored copy of areaCtrl resets to zero.
- R9: While rstN is low, intSel, extSel and cfgChanged are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| areaCtrl | input | 32 | Four control bytes; byte k serves area k |
| addr | input | 20 | Physical address of the access |
| isWrite | input | 1 | 1 for a write, 0 for a read |
| intSel | output | 1 | Registered: serve from internal DRAM |
| extSel | output | 1 | Registered: serve from the external bus |
| cfgChanged | output | 1 | One-cycle pulse after a control-byte change |

## Verification
An error in the area or segment decode sends one 16 KB segment to the wrong target. It shows at the selects one cycle after any access to that segment, so the random stimulus aims three quarters of its addresses into the window and sweeps every segment in directed tests. A wrong stored copy of the control bytes shows as a missing or extra cfgChanged pulse one cycle after the bytes change or stay the same. The bench therefore alternates between changing the bytes and holding them.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;
  typedef struct packed {
    logic claim;       // address lies in the shadow window
    logic toInternal;  // route to on-board DRAM
  } routeStrobe_t;
endpackage

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
  import shadow_route_pkg::*;
#(
  parameter int AREA_COUNT  = 4,
  parameter int SEG_COUNT   = 4,
  parameter int CTRL_W      = 8,
  parameter int RD_BIT      = 4,
  parameter int WR_BIT      = 5,
  parameter int PAGE_W      = 6,
  parameter int AREA_IDX_W  = $clog2(AREA_COUNT),
  parameter int SEG_IDX_W   = $clog2(SEG_COUNT)
) (
  input  logic [AREA_COUNT*CTRL_W-1:0] areaCtrl,
  input  logic [PAGE_W-1:0]            pageAddr,
  input  logic                         isWrite,
  output routeStrobe_t                 strobe
);
  localparam int TAG_W = PAGE_W - AREA_IDX_W - SEG_IDX_W;

  logic [SEG_IDX_W-1:0]  segIdx;
  logic [AREA_IDX_W-1:0] areaIdx;
  logic                  inWindow;
  logic [AREA_COUNT-1:0] areaInt;
  logic [AREA_COUNT-1:0] unusedHigh;

  assign segIdx   = pageAddr[SEG_IDX_W-1:0];
  assign areaIdx  = pageAddr[SEG_IDX_W +: AREA_IDX_W];
  assign inWindow = &pageAddr[PAGE_W-1 -: TAG_W];

  for (genvar i = 0; i < AREA_COUNT; i++) begin : gArea
    logic [CTRL_W-1:0]    cfg;
    logic [SEG_COUNT-1:0] segBits;
    logic                 routeBit;
    assign cfg      = areaCtrl[i*CTRL_W +: CTRL_W];
    assign segBits  = cfg[SEG_COUNT-1:0];
    assign routeBit = isWrite ? cfg[WR_BIT] : cfg[RD_BIT];
    assign areaInt[i] = (areaIdx == AREA_IDX_W'(i)) && segBits[segIdx] && routeBit;
    if (CTRL_W > WR_BIT + 1) begin : gSpare
      assign unusedHigh[i] = ^cfg[CTRL_W-1:WR_BIT+1];
    end else begin : gNoSpare
      assign unusedHigh[i] = 1'b0;
    end
  end

  assign strobe.claim      = inWindow;
  assign strobe.toInternal = inWindow && (|areaInt);
endmodule

// File: rtl/shadow_route_regs.sv
module shadow_route_regs
  import shadow_route_pkg::*;
#(
  parameter int CFG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  routeStrobe_t     strobe,
  input  logic [CFG_W-1:0] areaCtrl,
  output logic             intSel,
  output logic             extSel,
  output logic             cfgChanged
);
  logic [CFG_W-1:0] prevCtrl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intSel     <= 1'b0;
      extSel     <= 1'b0;
      cfgChanged <= 1'b0;
      prevCtrl   <= '0;
    end else begin
      intSel     <= strobe.claim && strobe.toInternal;
      extSel     <= strobe.claim && !strobe.toInternal;
      cfgChanged <= (areaCtrl != prevCtrl);
      prevCtrl   <= areaCtrl;
    end
  end
endmodule

// File: rtl/shadow_route_decoder.sv
module shadow_route_decoder
  import shadow_route_pkg::*;
#(
  parameter int AREA_COUNT  = 4,
  parameter int SEG_COUNT   = 4,
  parameter int CTRL_W      = 8,
  parameter int RD_BIT      = 4,
  parameter int WR_BIT      = 5,
  parameter int ADDR_W      = 20,
  parameter int AREA_ADDR_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [AREA_COUNT*CTRL_W-1:0] areaCtrl,
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         isWrite,
  output logic                         intSel,
  output logic                         extSel,
  output logic                         cfgChanged
);
  localparam int SEG_IDX_W = $clog2(SEG_COUNT);
  localparam int SEG_LSB   = AREA_ADDR_W - SEG_IDX_W;
  localparam int PAGE_W    = ADDR_W - SEG_LSB;

  routeStrobe_t strobe;
  logic         unusedOffset;

  assign unusedOffset = ^addr[SEG_LSB-1:0];

  shadow_route_ctrl #(
    .AREA_COUNT(AREA_COUNT), .SEG_COUNT(SEG_COUNT), .CTRL_W(CTRL_W),
    .RD_BIT(RD_BIT), .WR_BIT(WR_BIT), .PAGE_W(PAGE_W)
  ) uCtrl (
    .areaCtrl(areaCtrl),
    .pageAddr(addr[ADDR_W-1:SEG_LSB]),
    .isWrite (isWrite),
    .strobe  (strobe)
  );

  shadow_route_regs #(.CFG_W(AREA_COUNT*CTRL_W)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .areaCtrl  (areaCtrl),
    .intSel    (intSel),
    .extSel    (extSel),
    .cfgChanged(cfgChanged)
  );
endmodule

// File: rtl/shadow_route_checker.sv
module shadow_route_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] areaCtrl,
  input logic [19:0] addr,
  input logic        isWrite,
  input logic        intSel,
  input logic        extSel,
  input logic        cfgChanged
);
  logic       inWin;
  logic       segOn;
  logic [7:0] cfgByte;

  assign inWin   = (addr[19:18] == 2'b11);
  assign cfgByte = areaCtrl[{addr[17:16], 3'b000} +: 8];
  assign segOn   = cfgByte[addr[15:14]];

  // R7: never both selects
  assert_sel_mutex_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(intSel && extSel));

  // R7: inside the window one select follows a cycle later
  assert_sel_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    inWin |=> (intSel || extSel));

  // R6: outside the window nothing is claimed
  assert_outside_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> (!intSel && !extSel));

  // R5: a disabled segment goes external
  assert_disabled_ext_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && !segOn) |=> extSel);

  // R3: enabled read with read-route bit goes internal
  assert_read_int_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && segOn && !isWrite && cfgByte[4]) |=> intSel);

  // R4: enabled write with write-route bit goes internal
  assert_write_int_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inWin && segOn && isWrite && cfgByte[5]) |=> intSel);

  // R8: change pulse on edit, silence when held
  assert_change_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && areaCtrl != $past(areaCtrl)) |=> cfgChanged);
  assert_change_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && areaCtrl == $past(areaCtrl)) |=> !cfgChanged);
endmodule

bind shadow_route_decoder shadow_route_checker uChk (
  .clk(clk), .rstN(rstN), .areaCtrl(areaCtrl), .addr(addr), .isWrite(isWrite),
  .intSel(intSel), .extSel(extSel), .cfgChanged(cfgChanged)
);

// File: tb/sim_shadow_route_decoder.sv
`timescale 1ns/1ps
module sim_shadow_route_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] areaCtrl = '0;
  logic [19:0] addr = '0;
  logic        isWrite = 1'b0;
  logic        intSel, extSel, cfgChanged;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] benchPrev = '0;

  always #2 clk = ~clk;

  shadow_route_decoder u0 (
    .clk(clk), .rstN(rstN), .areaCtrl(areaCtrl), .addr(addr), .isWrite(isWrite),
    .intSel(intSel), .extSel(extSel), .cfgChanged(cfgChanged)
  );

  // {int, ext} expected from the requirements
  function automatic logic [1:0] expRoute(logic [19:0] a, logic wr, logic [31:0] c);
    logic [7:0] b;
    if (a[19:18] != 2'b11) return 2'b00;              // R6
    b = c[a[17:16]*8 +: 8];                            // R1
    if (!b[a[15:14]]) return 2'b01;                    // R2, R5
    if (wr ? b[5] : b[4]) return 2'b10;                // R3, R4
    return 2'b01;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic access(logic [19:0] a, logic wr, logic [31:0] c, string tag);
    logic [1:0] r;
    logic       chg;
    @(negedge clk);
    addr = a; isWrite = wr; areaCtrl = c;
    r = expRoute(a, wr, c);
    chg = (c != benchPrev);
    benchPrev = c;
    @(posedge clk); #1;
    check(tag, {intSel, extSel, 1'b0}, {r, 1'b0});
    check("R7", {1'b0, intSel && extSel, 1'b0}, 3'b000);
    check("R8", {2'b00, cfgChanged}, {2'b00, chg});
  endtask

  initial begin
    void'($urandom(32'd1409));
    // R9: reset state, with nonzero stimulus present
    repeat (3) @(negedge clk);
    addr = 20'hC0000; areaCtrl = '0;
    @(posedge clk); #1;
    check("R9", {intSel, extSel, cfgChanged}, 3'b000);
    @(negedge clk); rstN = 1'b1; benchPrev = '0;

    // R1: one area fully shadowed for reads, probe every area base
    for (int k = 0; k < 4; k++)
      for (int p = 0; p < 4; p++)
        access(20'hC0000 + 20'(p) * 20'h10000 + 20'h123, 1'b0, 32'h1F << (8*k), "R1");

    // R2: one segment enabled per area, probe all 16 segments, reads and writes
    for (int s = 0; s < 4; s++)
      for (int g = 0; g < 16; g++) begin
        access(20'hC0000 + 20'(g) * 20'h4000, 1'b0, {4{8'h30 | (8'h01 << s)}}, "R2");
        access(20'hC0000 + 20'(g) * 20'h4000 + 20'h3FFF, 1'b1, {4{8'h30 | (8'h01 << s)}}, "R2");
      end

    // R3 and R4: route bits separately
    access(20'hD4000, 1'b0, 32'h1F1F1F1F, "R3");
    access(20'hD4000, 1'b1, 32'h1F1F1F1F, "R4");
    access(20'hE8000, 1'b1, 32'h2F2F2F2F, "R4");
    access(20'hE8000, 1'b0, 32'h2F2F2F2F, "R3");

    // R5: routing bits set, enables clear
    access(20'hF0000, 1'b0, 32'hF0F0F0F0, "R5");
    access(20'hFFFFF, 1'b1, 32'hF0F0F0F0, "R5");

    // R6: window edges
    access(20'hBFFFF, 1'b0, 32'hFFFFFFFF, "R6");
    access(20'h00000, 1'b1, 32'hFFFFFFFF, "R6");
    access(20'hC0000, 1'b1, 32'hFFFFFFFF, "R6");

    // R8: change then hold several cycles
    access(20'hC0000, 1'b0, 32'h00000001, "R8");
    access(20'hC0000, 1'b0, 32'h00000001, "R8");
    access(20'hC0000, 1'b0, 32'h80000001, "R8");
    access(20'hC0000, 1'b0, 32'h80000001, "R8");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [19:0] a;
      logic [31:0] c;
      a = 20'($urandom);
      if ($urandom_range(3) != 0) a[19:18] = 2'b11;
      c = ($urandom_range(3) == 0) ? $urandom : benchPrev;
      access(a, 1'($urandom), c, "R7");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule